// File: doc/BRIEF.md
# Exception Pending Control Register

This block is a single 32-bit memory-mapped control and status word for a small interrupt controller. Software sets the pending state of three system exceptions through it: a non-maskable interrupt (NMI), a deferred service-call exception and a system-tick exception. Software can also clear the pending state of the last two. The same word reports read-only status that the rest of the controller drives:
- the number of the exception being handled
- the number of the highest-priority pending exception
- whether any interrupt is pending
- whether preempted exceptions are still active
- a flag telling whether the core would return to base level

The core sends one pulse per exception when it enters that exception's handler. The pulse clears the matching pending bit in hardware. A set and a handler-entry pulse in the same cycle leave the bit pending. When a set and a clear are written in the same access, the clear wins. The register only answers privileged accesses. An unprivileged access gets a bus error, zero read data and no change of state. The three pending bits also go out to the controller's arbitration logic.

The bus port takes one request per cycle. It answers a request that hits the register's offset one cycle later, with a one-cycle response strobe.

Top module: `exc_pend_reg`

## Requirements
- R1: After reset all three pending bits are 0 and the response strobe, error flag and read data are 0.
- R2: A request at the register's offset with privilege low gets a response with error flag 1 and read data 0. It changes no pending bit.
- R3: Writing 1 to bit 31 makes the NMI pending. Writing 0 there has no effect. A read returns the NMI pending state in bit 31.
- R4: An NMI handler-entry pulse clears the NMI pending bit. If an NMI set (register write or hardware request) occurs in the same cycle, the bit stays 1.
- R5: Writing 1 to bit 28 makes the deferred-service exception pending. Writing 1 to bit 27 clears it. Writing 1 to both clears it. A read returns the pending state in bit 28.
- R6: Writing 1 to bit 26 makes the system-tick exception pending. Writing 1 to bit 25 clears it. Writing 1 to both clears it. A read returns the pending state in bit 26.
- R7: The deferred-service and system-tick handler-entry pulses clear their own pending bits. A set written in the same cycle wins over the pulse.
- R8: A read returns these status fields, and writes to them have no effect:
  - active exception number in bits 7:0
  - return-to-base flag in bit 11
  - pending exception number in bits 19:12
  - interrupt-pending flag in bit 22
  - preempted-active flag in bit 23

  Bits 30:29, 27, 25, 24, 21:20 and 10:8 read as 0.
- R9: A request at the register's offset is answered exactly one cycle later by a one-cycle response strobe. Requests at other offsets get no response and change nothing.
- R10: A high NMI request input makes the NMI pending without a bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request valid |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | 12 | Byte offset within the system control space |
| wdata_i | input | 32 | Write data |
| priv_i | input | 1 | Request comes from privileged mode |
| rvalid_o | output | 1 | Response strobe, one cycle after a hit |
| rdata_o | output | 32 | Read data, 0 for writes and errors |
| err_o | output | 1 | Bus error response |
| nmi_req_i | input | 1 | Hardware NMI request |
| nmi_entry_i | input | 1 | Core enters the NMI handler |
| dsv_entry_i | input | 1 | Core enters the deferred-service handler |
| tick_entry_i | input | 1 | Core enters the system-tick handler |
| act_num_i | input | 8 | Active exception number |
| ret_base_i | input | 1 | Return-to-base flag |
| pend_num_i | input | 8 | Highest-priority pending exception number |
| irq_pend_i | input | 1 | Some interrupt is pending |
| preempt_i | input | 1 | Preempted exceptions are active |
| nmi_pend_o | output | 1 | NMI pending |
| dsv_pend_o | output | 1 | Deferred-service exception pending |
| tick_pend_o | output | 1 | System-tick exception pending |

## Verification
The pending bits are driven with several input patterns:
- A lone set, a lone clear and a set-plus-clear in one write separate the priority of the set and clear controls.
- A handler-entry pulse on its own, and a pulse in the same cycle as a set, separate hardware clearing from set priority.
- Writes of all zeros and all ones show that the read-only and reserved fields ignore writes, and that only the bits meant to act on a 1 do so.
- Unprivileged requests and requests at other offsets are checked against a known state. Any change to that state would show a refused access leaking into the register.

// File: rtl/exc_pend_pkg.sv
package exc_pend_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned NUM_EXC = 3;

  typedef enum logic [1:0] {
    EXC_NMI  = 2'd0,
    EXC_DSV  = 2'd1,
    EXC_TICK = 2'd2
  } exc_e;

  // bit positions software depends on
  localparam int unsigned B_NMI_SET    = 31;
  localparam int unsigned B_DSV_SET    = 28;
  localparam int unsigned B_DSV_CLR    = 27;
  localparam int unsigned B_TICK_SET   = 26;
  localparam int unsigned B_TICK_CLR   = 25;
  localparam int unsigned B_PREEMPT    = 23;
  localparam int unsigned B_IRQ_PEND   = 22;
  localparam int unsigned PEND_NUM_LSB = 12;
  localparam int unsigned B_RET_BASE   = 11;
  localparam int unsigned ACT_NUM_LSB  = 0;

  typedef struct packed {
    logic [VEC_W-1:0] act_num;
    logic             ret_base;
    logic [VEC_W-1:0] pend_num;
    logic             irq_pend;
    logic             preempt;
  } ctl_status_t;
endpackage

// File: rtl/exc_bus_decode.sv
module exc_bus_decode #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFFSET = 12'hD04,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              priv_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic              wr_en_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  logic hit, ok;

  assign hit     = req_i && (addr_i == OFFSET);
  assign ok      = hit && priv_i;
  assign wr_en_o = ok && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= hit;
      err_o    <= hit && !priv_i;
      rdata_o  <= (ok && !we_i) ? rd_word_i : '0;
    end
  end

  assert_unpriv_err_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !priv_i && addr_i == OFFSET) |=> (rvalid_o && err_o));
  assert_err_zero_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));
  assert_err_needs_resp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rvalid_o);
  assert_miss_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && addr_i == OFFSET) |=> !rvalid_o);
endmodule

// File: rtl/exc_pend_bit.sv
module exc_pend_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic hw_clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= 1'b0;
    else if (clr_i)    q_o <= 1'b0;   // clear beats set in one write
    else if (set_i)    q_o <= 1'b1;   // set beats handler entry
    else if (hw_clr_i) q_o <= 1'b0;
  end

  assert_clr_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o);
  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> q_o);
  assert_entry_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_clr_i && !set_i) |=> !q_o);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i && !hw_clr_i) |=> $stable(q_o));
endmodule

// File: rtl/exc_pend_reg.sv
module exc_pend_reg
  import exc_pend_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hD04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              priv_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  input  logic              nmi_req_i,
  input  logic              nmi_entry_i,
  input  logic              dsv_entry_i,
  input  logic              tick_entry_i,
  input  logic [VEC_W-1:0]  act_num_i,
  input  logic              ret_base_i,
  input  logic [VEC_W-1:0]  pend_num_i,
  input  logic              irq_pend_i,
  input  logic              preempt_i,
  output logic              nmi_pend_o,
  output logic              dsv_pend_o,
  output logic              tick_pend_o
);
  logic               wr_en;
  logic [DATA_W-1:0]  rd_word;
  logic [NUM_EXC-1:0] set_v, clr_v, entry_v, pend_q;
  ctl_status_t        stat;

  assign stat = '{act_num: act_num_i, ret_base: ret_base_i, pend_num: pend_num_i,
                  irq_pend: irq_pend_i, preempt: preempt_i};

  exc_bus_decode #(.ADDR_W(ADDR_W), .OFFSET(REG_OFFSET), .DATA_W(DATA_W)) u_dec (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .priv_i,
    .rd_word_i(rd_word), .wr_en_o(wr_en),
    .rvalid_o, .rdata_o, .err_o
  );

  always_comb begin
    set_v   = '0;
    clr_v   = '0;
    set_v[EXC_NMI]  = (wr_en && wdata_i[B_NMI_SET]) || nmi_req_i;
    set_v[EXC_DSV]  = wr_en && wdata_i[B_DSV_SET];
    clr_v[EXC_DSV]  = wr_en && wdata_i[B_DSV_CLR];
    set_v[EXC_TICK] = wr_en && wdata_i[B_TICK_SET];
    clr_v[EXC_TICK] = wr_en && wdata_i[B_TICK_CLR];
    entry_v = {tick_entry_i, dsv_entry_i, nmi_entry_i};
  end

  for (genvar g = 0; g < NUM_EXC; g++) begin : g_pend
    exc_pend_bit u_bit (
      .clk_i, .rst_ni,
      .set_i(set_v[g]), .clr_i(clr_v[g]), .hw_clr_i(entry_v[g]),
      .q_o(pend_q[g])
    );
  end

  assign nmi_pend_o  = pend_q[EXC_NMI];
  assign dsv_pend_o  = pend_q[EXC_DSV];
  assign tick_pend_o = pend_q[EXC_TICK];

  always_comb begin
    rd_word = '0;
    rd_word[B_NMI_SET]  = pend_q[EXC_NMI];
    rd_word[B_DSV_SET]  = pend_q[EXC_DSV];
    rd_word[B_TICK_SET] = pend_q[EXC_TICK];
    rd_word[B_PREEMPT]  = stat.preempt;
    rd_word[B_IRQ_PEND] = stat.irq_pend;
    rd_word[B_RET_BASE] = stat.ret_base;
    rd_word[PEND_NUM_LSB +: VEC_W] = stat.pend_num;
    rd_word[ACT_NUM_LSB  +: VEC_W] = stat.act_num;
  end

  assert_unpriv_keeps_state_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !priv_i && !nmi_req_i && !nmi_entry_i && !dsv_entry_i && !tick_entry_i)
    |=> $stable(pend_q));
  assert_rsvd_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rdata_o[30:29] == 2'b0 && !rdata_o[B_DSV_CLR] && !rdata_o[B_TICK_CLR]
                  && !rdata_o[24] && rdata_o[21:20] == 2'b0 && rdata_o[10:8] == 3'b0));
  assert_nmi_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_i |=> nmi_pend_o);
endmodule

// File: tb/exc_pend_reg_test.sv
module exc_pend_reg_test;
  localparam logic [11:0] OFS = 12'hD04;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 0, we = 0, priv = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rvalid, err;
  logic [31:0] rdata;
  logic nmi_req = 0, nmi_ent = 0, dsv_ent = 0, tick_ent = 0;
  logic [7:0] act_num = '0, pend_num = '0;
  logic ret_base = 0, irq_pend = 0, preempt = 0;
  logic nmi_p, dsv_p, tick_p;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  exc_pend_reg uut (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .priv_i(priv), .rvalid_o(rvalid), .rdata_o(rdata), .err_o(err),
    .nmi_req_i(nmi_req), .nmi_entry_i(nmi_ent), .dsv_entry_i(dsv_ent),
    .tick_entry_i(tick_ent), .act_num_i(act_num), .ret_base_i(ret_base),
    .pend_num_i(pend_num), .irq_pend_i(irq_pend), .preempt_i(preempt),
    .nmi_pend_o(nmi_p), .dsv_pend_o(dsv_p), .tick_pend_o(tick_p)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample at next negedge (after the posedge)
  task automatic cyc(input logic rq, input logic w, input logic [11:0] a,
                     input logic [31:0] d, input logic p, input logic [2:0] ent,
                     input logic nr);
    @(negedge clk);
    req = rq; we = w; addr = a; wdata = d; priv = p;
    {tick_ent, dsv_ent, nmi_ent} = ent; nmi_req = nr;
    @(negedge clk);
    req = 0; we = 0; {tick_ent, dsv_ent, nmi_ent} = '0; nmi_req = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    cyc(1, 1, OFS, d, 1, 3'b000, 0);
  endtask

  task automatic rd(output logic [31:0] v);
    cyc(1, 0, OFS, '0, 1, 3'b000, 0);
    v = rdata;
  endtask

  function automatic logic [2:0] pend3();
    return {tick_p, dsv_p, nmi_p};
  endfunction

  task automatic t_reset;
    chk("R1 pending", {29'b0, pend3()}, 0);
    chk("R1 rvalid", {31'b0, rvalid}, 0);
    chk("R1 err", {31'b0, err}, 0);
    chk("R1 rdata", rdata, 0);
  endtask

  task automatic t_nmi;
    logic [31:0] v;
    wr(32'h0);
    chk("R3 write 0 no effect", {31'b0, nmi_p}, 0);
    wr(32'h8000_0000);
    chk("R3 set", {31'b0, nmi_p}, 1);
    rd(v);
    chk("R3 read bit31", {31'b0, v[31]}, 1);
    cyc(0, 0, OFS, 0, 1, 3'b001, 0);
    chk("R4 entry clears", {31'b0, nmi_p}, 0);
    wr(32'h8000_0000);
    cyc(0, 0, OFS, 0, 1, 3'b001, 1);
    chk("R4 request during entry", {31'b0, nmi_p}, 1);
    cyc(1, 1, OFS, 32'h8000_0000, 1, 3'b001, 0);
    chk("R4 write during entry", {31'b0, nmi_p}, 1);
    cyc(0, 0, OFS, 0, 1, 3'b001, 0);
    cyc(0, 0, OFS, 0, 1, 3'b000, 1);
    chk("R10 hw request", {31'b0, nmi_p}, 1);
    cyc(0, 0, OFS, 0, 1, 3'b001, 0);
  endtask

  task automatic t_dsv;
    logic [31:0] v;
    wr(32'h1000_0000);
    chk("R5 set", {31'b0, dsv_p}, 1);
    rd(v);
    chk("R5 read bit28", {31'b0, v[28]}, 1);
    wr(32'h0800_0000);
    chk("R5 clear", {31'b0, dsv_p}, 0);
    wr(32'h1000_0000);
    wr(32'h1800_0000);
    chk("R5 both clears", {31'b0, dsv_p}, 0);
    wr(32'h1800_0000);
    chk("R5 both from clear", {31'b0, dsv_p}, 0);
  endtask

  task automatic t_tick;
    logic [31:0] v;
    wr(32'h0400_0000);
    chk("R6 set", {31'b0, tick_p}, 1);
    rd(v);
    chk("R6 read bit26", {31'b0, v[26]}, 1);
    wr(32'h0200_0000);
    chk("R6 clear", {31'b0, tick_p}, 0);
    wr(32'h0400_0000);
    wr(32'h0600_0000);
    chk("R6 both clears", {31'b0, tick_p}, 0);
  endtask

  task automatic t_entry;
    wr(32'h1400_0000);
    chk("R7 both set", {30'b0, dsv_p, tick_p}, 2'b11);
    cyc(0, 0, OFS, 0, 1, 3'b010, 0);
    chk("R7 dsv entry", {30'b0, dsv_p, tick_p}, 2'b01);
    cyc(0, 0, OFS, 0, 1, 3'b100, 0);
    chk("R7 tick entry", {30'b0, dsv_p, tick_p}, 2'b00);
    cyc(1, 1, OFS, 32'h1400_0000, 1, 3'b110, 0);
    chk("R7 set beats entry", {30'b0, dsv_p, tick_p}, 2'b11);
    wr(32'h0A00_0000);
  endtask

  task automatic t_unpriv;
    wr(32'h9400_0000);
    cyc(1, 1, OFS, 32'h0A00_0000, 0, 3'b000, 0);
    chk("R2 write err", {31'b0, err}, 1);
    chk("R2 write rdata", rdata, 0);
    chk("R2 state kept", {29'b0, pend3()}, 3'b111);
    cyc(1, 0, OFS, 0, 0, 3'b000, 0);
    chk("R2 read err", {31'b0, err}, 1);
    chk("R2 read data zero", rdata, 0);
    wr(32'h0A00_0000);
    cyc(0, 0, OFS, 0, 1, 3'b001, 0);
  endtask

  task automatic t_status;
    logic [31:0] v, e;
    act_num = 8'hA5; pend_num = 8'h3C; ret_base = 1; irq_pend = 1; preempt = 1;
    wr(32'hFFFF_FFFF);
    chk("R8 write all ones", {29'b0, pend3()}, 3'b001);
    rd(v);
    e = 32'h8000_0000 | (32'h1 << 23) | (32'h1 << 22) | (32'h3C << 12) | (32'h1 << 11) | 32'hA5;
    chk("R8 fields", v, e);
    act_num = 8'h00; pend_num = 8'hFF; ret_base = 0; irq_pend = 0; preempt = 0;
    wr(32'h0);
    rd(v);
    chk("R8 fields after zero write", v, 32'h8000_0000 | (32'hFF << 12));
    cyc(0, 0, OFS, 0, 1, 3'b001, 0);
  endtask

  task automatic t_offset;
    cyc(1, 1, 12'hD08, 32'h9400_0000, 1, 3'b000, 0);
    chk("R9 miss no response", {31'b0, rvalid}, 0);
    chk("R9 miss no effect", {29'b0, pend3()}, 0);
    @(negedge clk); req = 1; we = 0; addr = OFS; priv = 1;
    @(negedge clk); req = 0;
    chk("R9 response after one cycle", {31'b0, rvalid}, 1);
    @(negedge clk);
    chk("R9 strobe one cycle", {31'b0, rvalid}, 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_nmi();
    t_dsv();
    t_tick();
    t_entry();
    t_unpriv();
    t_status();
    t_offset();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule